// File: doc/BRIEF.md
# Segmented Ramp Code Sequencer

This block drives the digital side of a current-steering ramp DAC used by column-parallel single-slope converters. It keeps one ramp code, the forward code, and derives from it a complementary code so that the two always add up to full scale. Both codes leave the block in segmented form: the five low bits as plain binary switch controls and the six high bits expanded into 63 thermometer switch lines.

Each frame consists of two ramps. A start pulse from the sequencing logic launches the reset-phase ramp from zero. When it has taken its programmed number of steps, the outputs return to their idle levels for a programmable hold interval, during which a start request is not honoured. A second start pulse then launches the signal-phase ramp. In the signal phase the forward code does not begin at zero but at a fixed-error correction value supplied by a calibration block. This lowers the starting point of the complementary output by the same amount. The correction value may be written at any time, and it is captured for use once per frame.

Top module: `rampseq_top`

## Requirements
- R1: For each output, the binary field equals the low 5 bits of that output's code, and thermometer line k (k = 0..62) is high exactly when code bits [10:5], read as an unsigned number, are greater than k.
- R2: In every cycle, rc_code_o equals 2047 minus rf_code_o.
- R3: After reset, and in every cycle outside a ramp, rf_code_o is 0, rc_code_o is 2047, done_o is 0 and ramp_active_o is 0.
- R4: If start_i is sampled high on clock edge S, rf_code_o shows the phase's start code after edge S+1. After that it rises by one for every edge on which step_en_i was high and holds on every edge on which step_en_i was low. ramp_active_o is high in every cycle that shows a ramp code.
- R5: A ramp ends after steps_i enabled steps, where steps_i is sampled with the start pulse. done_o is high for exactly one cycle, the cycle in which rf_code_o shows the final code. The next cycle shows idle levels. When steps_i is 0, the done cycle is the first ramp cycle.
- R6: rf_code_o saturates at 2047 and does not wrap, while step counting continues.
- R7: After the reset-phase ramp ends on edge E (the edge that raises done_o), start_i is ignored on edges E+1 to E+H, where H is hold_i sampled at the frame's first start. It is accepted on any later edge.
- R8: The signal-phase ramp starts with rf_code_o equal to the frame's correction value, so rc_code_o starts at 2047 minus that value. sig_phase_o is high during the signal ramp and low during the reset ramp.
- R9: fix_load_i captures fix_off_i on any edge. The value used by a signal phase is the one held when that frame's reset-phase start was accepted, so a load made during a frame takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches the next ramp phase |
| step_en_i | input | 1 | Advances the active ramp by one code |
| steps_i | input | 12 | Step count for the phase being launched |
| hold_i | input | 8 | Hold interval length, sampled at frame start |
| fix_off_i | input | 11 | Fixed-error correction value |
| fix_load_i | input | 1 | Captures fix_off_i |
| rf_code_o | output | 11 | Forward ramp code |
| rc_code_o | output | 11 | Complementary ramp code |
| rf_bin_o | output | 5 | Forward code binary switch lines |
| rf_therm_o | output | 63 | Forward code thermometer switch lines |
| rc_bin_o | output | 5 | Complementary code binary switch lines |
| rc_therm_o | output | 63 | Complementary code thermometer switch lines |
| done_o | output | 1 | One-cycle end-of-ramp pulse |
| ramp_active_o | output | 1 | Outputs currently show a ramp code |
| sig_phase_o | output | 1 | Current ramp is the signal phase |

## Verification
The bench aims at the hold window. Start pulses fall on the last ignored edges, where a counter that is off by one would launch the signal ramp early and show the correction value one cycle too soon. A correction value is loaded in the middle of a frame to catch a design that applies it at once rather than in the next frame. A zero step count and a ramp that runs into full scale test the end conditions: a wrapping accumulator would drop to small codes and turn the thermometer lines back off. A stalled step enable shows whether the ramp holds its code and whether the done pulse waits for enabled steps only, rather than counting every cycle.

// File: rtl/rampseq_pkg.sv
package rampseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RRAMP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_SRAMP = 2'd3
  } seq_st_t;
endpackage

// File: rtl/rampseq_ctrl.sv
module rampseq_ctrl
  import rampseq_pkg::*;
#(
  parameter int CODE_W = 11,
  parameter int STEP_W = 12,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              step_en_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [CODE_W-1:0] fix_off_i,
  input  logic              fix_load_i,
  output logic              ld_o,
  output logic [CODE_W-1:0] ld_val_o,
  output logic              inc_o,
  output logic              done_o,
  output logic              ramp_o,
  output logic              sig_o
);
  seq_st_t           st_q, st_d;
  logic [STEP_W-1:0] cnt_q, steps_q;
  logic [HOLD_W-1:0] hcnt_q, hold_q;
  logic [CODE_W-1:0] off_q, off_act_q;
  logic              done_q, end_ramp, phase_go;

  // phase sequencing: every phase entry or exit reloads the code register
  always_comb begin
    st_d     = st_q;
    ld_o     = 1'b0;
    ld_val_o = '0;
    inc_o    = 1'b0;
    end_ramp = 1'b0;
    phase_go = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_RRAMP;
          ld_o     = 1'b1;
          phase_go = 1'b1;
        end
      end
      ST_RRAMP: begin
        if (cnt_q == steps_q) begin
          st_d     = ST_HOLD;
          ld_o     = 1'b1;
          end_ramp = 1'b1;
        end else begin
          inc_o = step_en_i;
        end
      end
      ST_HOLD: begin
        if (hcnt_q == hold_q && start_i) begin
          st_d     = ST_SRAMP;
          ld_o     = 1'b1;
          ld_val_o = off_act_q;
          phase_go = 1'b1;
        end
      end
      ST_SRAMP: begin
        if (cnt_q == steps_q) begin
          st_d     = ST_IDLE;
          ld_o     = 1'b1;
          end_ramp = 1'b1;
        end else begin
          inc_o = step_en_i;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      steps_q   <= '0;
      hcnt_q    <= '0;
      hold_q    <= '0;
      off_q     <= '0;
      off_act_q <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= end_ramp;
      if (fix_load_i) off_q <= fix_off_i;
      if (phase_go) begin
        steps_q <= steps_i;
        cnt_q   <= '0;
      end else if (inc_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
      // frame-level values are frozen when the reset-phase ramp is launched
      if (st_q == ST_IDLE && start_i) begin
        hold_q    <= hold_i;
        off_act_q <= off_q;
      end
      if (st_q == ST_RRAMP) hcnt_q <= '0;
      else if (st_q == ST_HOLD && hcnt_q != hold_q) hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
  assign ramp_o = (st_q == ST_RRAMP) || (st_q == ST_SRAMP);
  assign sig_o  = (st_q == ST_SRAMP);

  // R5: the end-of-ramp pulse never lasts two cycles
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7: the hold interval cannot be left before its count is reached
  p_hold_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && hcnt_q != hold_q) |=> (st_q == ST_HOLD));

  // R9: the correction in use stays fixed for the whole frame
  p_frame_off_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(off_act_q));
endmodule

// File: rtl/rampseq_acc.sv
module rampseq_acc #(
  parameter int CODE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] ld_val_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] PEAK = '1;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)                         code_q <= '0;
    else if (ld_i)                   code_q <= ld_val_i;
    else if (inc_i && code_q != PEAK) code_q <= code_q + 1'b1;
  end

  assign code_o = code_q;

  // R4: one enabled step moves the code up by exactly one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && code_q != PEAK) |=> (code_q == $past(code_q) + 1'b1));

  // R6: full scale is sticky while stepping
  p_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && code_q == PEAK) |=> (code_q == PEAK));
endmodule

// File: rtl/rampseq_seg.sv
module rampseq_seg #(
  parameter int          CODE_W   = 11,
  parameter int          BIN_W    = 5,
  parameter logic [31:0] RST_CODE = 32'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic [BIN_W-1:0]  bin_o,
  output logic [(1<<(CODE_W-BIN_W))-2:0] therm_o
);
  localparam int TW    = CODE_W - BIN_W;
  localparam int LINES = (1 << TW) - 1;
  localparam logic [CODE_W-1:0] RST_C = RST_CODE[CODE_W-1:0];

  logic [TW-1:0]    upper;
  logic [LINES-1:0] therm_d, therm_rst;

  assign upper = code_i[CODE_W-1:BIN_W];

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm_d[k]   = (upper > TW'(k));
    assign therm_rst[k] = (RST_C[CODE_W-1:BIN_W] > TW'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= RST_C;
      bin_o   <= RST_C[BIN_W-1:0];
      therm_o <= therm_rst;
    end else begin
      code_o  <= code_i;
      bin_o   <= code_i[BIN_W-1:0];
      therm_o <= therm_d;
    end
  end

  // R1: number of active thermometer lines tracks the upper code field
  p_therm_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_o) == int'(code_o[CODE_W-1:BIN_W]));
endmodule

// File: rtl/rampseq_top.sv
module rampseq_top #(
  parameter int CODE_W = 11,
  parameter int BIN_W  = 5,
  parameter int STEP_W = 12,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              step_en_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [CODE_W-1:0] fix_off_i,
  input  logic              fix_load_i,
  output logic [CODE_W-1:0] rf_code_o,
  output logic [CODE_W-1:0] rc_code_o,
  output logic [BIN_W-1:0]  rf_bin_o,
  output logic [(1<<(CODE_W-BIN_W))-2:0] rf_therm_o,
  output logic [BIN_W-1:0]  rc_bin_o,
  output logic [(1<<(CODE_W-BIN_W))-2:0] rc_therm_o,
  output logic              done_o,
  output logic              ramp_active_o,
  output logic              sig_phase_o
);
  localparam logic [CODE_W-1:0] PEAK = '1;

  logic              ld, inc, ramp_c, sig_c;
  logic [CODE_W-1:0] ld_val, rf_c, rc_c;

  rampseq_ctrl #(.CODE_W(CODE_W), .STEP_W(STEP_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk, .rst, .start_i, .step_en_i, .steps_i, .hold_i, .fix_off_i, .fix_load_i,
    .ld_o(ld), .ld_val_o(ld_val), .inc_o(inc), .done_o(done_o),
    .ramp_o(ramp_c), .sig_o(sig_c)
  );

  rampseq_acc #(.CODE_W(CODE_W)) u_acc (
    .clk, .rst, .ld_i(ld), .ld_val_i(ld_val), .inc_i(inc), .code_o(rf_c)
  );

  assign rc_c = PEAK - rf_c;

  rampseq_seg #(.CODE_W(CODE_W), .BIN_W(BIN_W), .RST_CODE(32'd0)) u_seg_rf (
    .clk, .rst, .code_i(rf_c), .code_o(rf_code_o), .bin_o(rf_bin_o), .therm_o(rf_therm_o)
  );

  rampseq_seg #(.CODE_W(CODE_W), .BIN_W(BIN_W), .RST_CODE(32'(PEAK))) u_seg_rc (
    .clk, .rst, .code_i(rc_c), .code_o(rc_code_o), .bin_o(rc_bin_o), .therm_o(rc_therm_o)
  );

  // phase flags are delayed to line up with the registered codes
  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_active_o <= 1'b0;
      sig_phase_o   <= 1'b0;
    end else begin
      ramp_active_o <= ramp_c;
      sig_phase_o   <= sig_c;
    end
  end

  // R2: the two output registers always sum to full scale
  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (rf_code_o + rc_code_o) == PEAK);
endmodule

// File: tb/sim_rampseq_top.sv
module sim_rampseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, step_en_i = 1'b1, fix_load_i = 1'b0;
  logic [11:0] steps_i = '0;
  logic [7:0]  hold_i = '0;
  logic [10:0] fix_off_i = '0;
  logic [10:0] rf_code_o, rc_code_o;
  logic [4:0]  rf_bin_o, rc_bin_o;
  logic [62:0] rf_therm_o, rc_therm_o;
  logic        done_o, ramp_active_o, sig_phase_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rampseq_top u0 (.*);

  function automatic logic [62:0] exp_therm(input logic [10:0] c);
    logic [62:0] t;
    for (int k = 0; k < 63; k++) t[k] = (int'(c[10:5]) > k);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 and R2 watched in every cycle after reset
  always @(negedge clk) if (!rst) begin
    chk(rc_code_o == 11'(2047 - int'(rf_code_o)), "R2 sum", rc_code_o, 2047 - int'(rf_code_o));
    chk(rf_therm_o == exp_therm(rf_code_o) && rf_bin_o == rf_code_o[4:0],
        "R1 rf segments", rf_therm_o, exp_therm(rf_code_o));
    chk(rc_therm_o == exp_therm(rc_code_o) && rc_bin_o == rc_code_o[4:0],
        "R1 rc segments", rc_therm_o, exp_therm(rc_code_o));
  end

  // called right after a negedge; returns right after the idle cycle that follows done
  task automatic run_ramp(input int steps, input int first, input bit sig, input string tag);
    int k = 0;
    int fin = (first + steps > 2047) ? 2047 : first + steps;
    steps_i = 12'(steps);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      @(negedge clk);
      k++;
      if (done_o || k > steps + 40) break;
      chk(int'(rf_code_o) == ((first + k - 1 > 2047) ? 2047 : first + k - 1),
          {"R4 ", tag}, rf_code_o, first + k - 1);
      chk(ramp_active_o && sig_phase_o == sig, {"R8 flags ", tag}, sig_phase_o, sig);
    end
    chk(done_o && k == steps + 1, {"R5 done timing ", tag}, k, steps + 1);
    chk(int'(rf_code_o) == fin, {"R5 final code ", tag}, rf_code_o, fin);
    @(negedge clk);
    chk(!done_o && rf_code_o == 0 && !ramp_active_o, {"R3 idle after ", tag}, rf_code_o, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rf_code_o == 0 && rc_code_o == 2047, "R3 reset codes", rf_code_o, 0);
    chk(!done_o && !ramp_active_o, "R3 reset flags", done_o, 0);
    chk(rc_therm_o == '1 && rf_therm_o == '0, "R1 reset lines", rc_therm_o, 64'h7fff_ffff_ffff_ffff);
  endtask

  task automatic t_frame_hold;
    fix_off_i = 11'd100; fix_load_i = 1'b1;
    @(negedge clk);
    fix_load_i = 1'b0; hold_i = 8'd3;
    run_ramp(5, 0, 1'b0, "reset ramp");
    // R7: start on edges E+2 and E+3 (inside hold of 3) must be ignored
    start_i = 1'b1; fix_off_i = 11'd500; fix_load_i = 1'b1;
    @(negedge clk);
    fix_load_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(!ramp_active_o && rf_code_o == 0, "R7 start ignored in hold", rf_code_o, 0);
    // R8/R9: signal ramp begins at the correction held at frame start (100)
    run_ramp(6, 100, 1'b1, "signal ramp offset");
  endtask

  task automatic t_stall;
    hold_i = 8'd0; steps_i = 12'd4; step_en_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(ramp_active_o && rf_code_o == 0, "R4 ramp started", rf_code_o, 0);
    @(negedge clk);
    @(negedge clk);
    chk(rf_code_o == 0 && !done_o, "R4 stalled hold", rf_code_o, 0);
    step_en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(rf_code_o == 3 && !done_o, "R5 counts enabled steps", rf_code_o, 3);
    @(negedge clk);
    chk(done_o && rf_code_o == 4, "R5 done after stall", rf_code_o, 4);
    @(negedge clk);
    chk(rf_code_o == 0 && !done_o, "R3 idle after stall", rf_code_o, 0);
    // R9: the correction loaded mid-frame earlier (500) applies now
    run_ramp(3, 500, 1'b1, "next-frame offset");
  endtask

  task automatic t_saturate;
    fix_off_i = 11'd2040; fix_load_i = 1'b1;
    @(negedge clk);
    fix_load_i = 1'b0; hold_i = 8'd0;
    run_ramp(0, 0, 1'b0, "zero steps");
    steps_i = 12'd20; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(rf_code_o == 2047 && rc_code_o == 0, "R6 saturated", rf_code_o, 2047);
    chk(rf_therm_o == '1 && rc_therm_o == '0, "R6 lines at full scale", rf_therm_o, 64'h7fff_ffff_ffff_ffff);
    @(negedge clk);
    chk(done_o && rf_code_o == 2047, "R6 done at full scale", rf_code_o, 2047);
    @(negedge clk);
    chk(rf_code_o == 0 && rc_code_o == 2047, "R3 idle after saturation", rf_code_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_frame_hold();
    t_stall();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule